// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers the event strobes of a seven-channel display controller into two status words and drives a single level interrupt toward the system interrupt controller. Each DMA channel reports start-of-frame, end-of-frame, branch-taken, bus-error and input-underrun strobes. The controller as a whole reports last-frame-done, AC-bias count, output underrun, read-status and command-complete. Every strobe sets a sticky bit at a fixed position. Software clears these bits by writing ones.

A small write port also carries a control word, which holds the word-0 mask bits and the controller enable, and a mask word for the per-channel bits of status word 1. When a frame-related event is not masked, the unit either latches the 32-bit frame ID of the reporting channel or, if the interrupt is already high, sets a secondary-interrupt flag and leaves the latched ID untouched. The interrupt line is a register. It is re-evaluated every cycle from the current status and mask values.

Top module: `dispirq_status`

## Requirements
- R1: After reset, both status words, the control word, the mask word and the interrupt ID read zero, and the interrupt output is low.
- R2: Status word 0 events land on these bits: last-frame-done bit 0, channel 0 start-of-frame bit 1, AC-bias bit 3, channel 0 underrun bit 4, channel 1 underrun bit 5, output underrun bit 6, channel 0 end-of-frame bit 8, channel 0 branch bit 9, read-status bit 11, command bit 12.
- R3: For channel c in 1..6, status word 1 places start-of-frame at bit c-1, end-of-frame at bit c+7 and branch at bit c+15. Underrun of channels 2..6 goes to bit c+23.
- R4: A bus error on any channel sets status word 0 bit 2 and writes the lowest erroring channel number into bits 30:28. It has no mask and does not itself drive the interrupt.
- R5: One cycle after the status changes, the interrupt output equals the OR of the word-0 source bits (0,1,4,5,6,7,8,9,11,12) whose mask is clear, ORed with the status word 1 bits whose bit in the mask word (address 3) is clear. Word-0 masks sit at the same positions in the control word (address 2), except that bit 5 is masked by mask word bit 24.
- R6: When an unmasked start-of-frame, end-of-frame or branch event, or any bus error, occurs while the interrupt output is low, the interrupt ID takes the frame ID of the lowest-numbered such channel.
- R7: If such an event occurs while the interrupt output is high, status word 0 bit 10 is set and the interrupt ID is unchanged.
- R8: A write to address 0 clears the status word 0 bits that are set in the low 12 bits of the data. When data bit 2 is one, bits 30:28 are also cleared. Bit 12 cannot be cleared.
- R9: A write to address 1 clears only the status word 1 bits that are set in the data ANDed with 0x3E3F3F.
- R10: When a clear write and a new event hit the same bit in one cycle, the bit ends up set.
- R11: Writing the control word with bit 16 (enable) zero while enable was one sets status word 0 bit 7 (quick-disable).
- R12: Strobes from several channels in the same cycle are all recorded in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sof | input | NUM_CH | Start-of-frame strobe per channel |
| ev_eof | input | NUM_CH | End-of-frame strobe per channel |
| ev_branch | input | NUM_CH | Branch-taken strobe per channel |
| ev_buserr | input | NUM_CH | Bus-error strobe per channel |
| ev_underrun | input | NUM_CH | Input-underrun strobe per channel |
| ev_last_done | input | 1 | Last frame finished |
| ev_acbias | input | 1 | AC-bias count reached |
| ev_out_underrun | input | 1 | Output FIFO underrun |
| ev_read_status | input | 1 | Panel read status ready |
| ev_command | input | 1 | Command completed |
| frame_ids | input | NUM_CH*ID_W | Current frame ID of each channel, channel 0 in the low bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 status 0, 1 status 1, 2 control, 3 mask word |
| wr_data | input | 32 | Write data |
| status0_o | output | 32 | Status word 0 |
| status1_o | output | 32 | Status word 1 |
| int_id_o | output | ID_W | Latched interrupt frame ID |
| irq_o | output | 1 | Level interrupt |

## Verification
Two situations can fall in one cycle here. A write-one-to-clear can meet a fresh strobe on the same bit, and a new unmasked event can arrive in the same cycle that the registered interrupt is already high. The bench provokes the first by writing a clear on the edge where the event strobe is driven, and it expects the bit to stay set. It provokes the second by firing a channel event right after the line has risen, and it expects the secondary flag to be set and the ID to be held. Long random runs overlap strobes, clears and mask writes freely, and every cycle is judged against a bench model.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;
    localparam int unsigned DW = 32;

    // status word 0 positions
    localparam int unsigned B_LDONE  = 0;
    localparam int unsigned B_SOF0   = 1;
    localparam int unsigned B_BERR   = 2;
    localparam int unsigned B_ACB    = 3;
    localparam int unsigned B_UR0    = 4;
    localparam int unsigned B_UR1    = 5;
    localparam int unsigned B_OUR    = 6;
    localparam int unsigned B_QDIS   = 7;
    localparam int unsigned B_EOF0   = 8;
    localparam int unsigned B_BR0    = 9;
    localparam int unsigned B_SINT   = 10;
    localparam int unsigned B_RDST   = 11;
    localparam int unsigned B_CMD    = 12;
    localparam int unsigned F_ERR_LO = 28;
    localparam int unsigned F_ERR_W  = 3;

    // control word: enable bit, mask for word-0 underrun ch1 lives in mask word
    localparam int unsigned B_EN     = 16;
    localparam int unsigned B_M_UR1  = 24;

    // status word 1 offsets per event kind (added to channel number)
    localparam int unsigned OFS_SOF  = 0;   // bit c-1
    localparam int unsigned OFS_EOF  = 8;   // bit c+7
    localparam int unsigned OFS_BR   = 16;  // bit c+15
    localparam int unsigned OFS_UR   = 24;  // bit c+23

    localparam logic [DW-1:0] ST0_CLR  = 32'h0000_0FFF;
    localparam logic [DW-1:0] ST1_CLR  = 32'h003E_3F3F;
    localparam logic [DW-1:0] ST0_SRC  = 32'h0000_1BF3;
    localparam logic [DW-1:0] CTL_WR   = 32'h0001_1BD3;
    localparam logic [DW-1:0] MSK1_WR  = 32'h3F3F_3F3F;

    typedef enum logic [1:0] {
        A_ST0  = 2'd0,
        A_ST1  = 2'd1,
        A_CTL  = 2'd2,
        A_MSK1 = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/dispirq_prio.sv
module dispirq_prio #(
    parameter int unsigned N  = 7,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dispirq_map.sv
module dispirq_map
    import dispirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 7
) (
    input  logic [NUM_CH-1:0] ev_sof,
    input  logic [NUM_CH-1:0] ev_eof,
    input  logic [NUM_CH-1:0] ev_branch,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_underrun,
    input  logic [DW-1:0]     ctrl_q,
    input  logic [DW-1:0]     mask1_q,
    output logic [DW-1:0]     set0,
    output logic [DW-1:0]     set1,
    output logic [NUM_CH-1:0] hit
);
    always_comb begin
        set0 = '0;
        set1 = '0;
        hit  = '0;
        set0[B_SOF0] = ev_sof[0];
        set0[B_EOF0] = ev_eof[0];
        set0[B_BR0]  = ev_branch[0];
        set0[B_UR0]  = ev_underrun[0];
        hit[0] = (ev_sof[0]    & ~ctrl_q[B_SOF0])
               | (ev_eof[0]    & ~ctrl_q[B_EOF0])
               | (ev_branch[0] & ~ctrl_q[B_BR0])
               | ev_buserr[0];
        for (int c = 1; c < int'(NUM_CH); c++) begin
            set1[OFS_SOF + c - 1] = ev_sof[c];
            set1[OFS_EOF + c - 1] = ev_eof[c];
            set1[OFS_BR  + c - 1] = ev_branch[c];
            if (c == 1) set0[B_UR1] = ev_underrun[c];
            else        set1[OFS_UR + c - 1] = ev_underrun[c];
            hit[c] = (ev_sof[c]    & ~mask1_q[OFS_SOF + c - 1])
                   | (ev_eof[c]    & ~mask1_q[OFS_EOF + c - 1])
                   | (ev_branch[c] & ~mask1_q[OFS_BR  + c - 1])
                   | ev_buserr[c];
        end
    end
endmodule

// File: rtl/dispirq_status.sv
module dispirq_status
    import dispirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 7,
    parameter int unsigned ID_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      ev_sof,
    input  logic [NUM_CH-1:0]      ev_eof,
    input  logic [NUM_CH-1:0]      ev_branch,
    input  logic [NUM_CH-1:0]      ev_buserr,
    input  logic [NUM_CH-1:0]      ev_underrun,
    input  logic                   ev_last_done,
    input  logic                   ev_acbias,
    input  logic                   ev_out_underrun,
    input  logic                   ev_read_status,
    input  logic                   ev_command,
    input  logic [NUM_CH*ID_W-1:0] frame_ids,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic [DW-1:0]          status0_o,
    output logic [DW-1:0]          status1_o,
    output logic [ID_W-1:0]        int_id_o,
    output logic                   irq_o
);
    localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [DW-1:0]   s0;
        logic [DW-1:0]   s1;
        logic [DW-1:0]   ctrl;
        logic [DW-1:0]   m1;
        logic [ID_W-1:0] id;
        logic            irq;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0]     map_set0, map_set1;
    logic [NUM_CH-1:0] hit;
    logic              hit_any, ber_any;
    logic [IW-1:0]     hit_idx, ber_idx;

    dispirq_map #(.NUM_CH(NUM_CH)) u_map (
        .ev_sof      (ev_sof),
        .ev_eof      (ev_eof),
        .ev_branch   (ev_branch),
        .ev_buserr   (ev_buserr),
        .ev_underrun (ev_underrun),
        .ctrl_q      (st_q.ctrl),
        .mask1_q     (st_q.m1),
        .set0        (map_set0),
        .set1        (map_set1),
        .hit         (hit)
    );

    dispirq_prio #(.N(NUM_CH), .IW(IW)) u_hit_prio (
        .req   (hit),
        .valid (hit_any),
        .idx   (hit_idx)
    );

    dispirq_prio #(.N(NUM_CH), .IW(IW)) u_err_prio (
        .req   (ev_buserr),
        .valid (ber_any),
        .idx   (ber_idx)
    );

    always_comb begin
        logic [DW-1:0]      glob;
        logic [DW-1:0]      mask0_eff;
        logic [F_ERR_W-1:0] err_field;

        st_d = st_q;

        glob = '0;
        glob[B_LDONE] = ev_last_done;
        glob[B_ACB]   = ev_acbias;
        glob[B_OUR]   = ev_out_underrun;
        glob[B_RDST]  = ev_read_status;
        glob[B_CMD]   = ev_command;
        glob[B_BERR]  = ber_any;

        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_ST0: begin
                    st_d.s0 = st_d.s0 & ~(wr_data & ST0_CLR);
                    if (wr_data[B_BERR]) st_d.s0[F_ERR_LO +: F_ERR_W] = '0;
                end
                A_ST1:  st_d.s1 = st_d.s1 & ~(wr_data & ST1_CLR);
                A_CTL: begin
                    st_d.ctrl = wr_data & CTL_WR;
                    if (st_q.ctrl[B_EN] && !wr_data[B_EN]) glob[B_QDIS] = 1'b1;
                end
                A_MSK1: st_d.m1 = wr_data & MSK1_WR;
                default: ;
            endcase
        end

        st_d.s0 = st_d.s0 | map_set0 | glob;
        st_d.s1 = st_d.s1 | map_set1;

        err_field = F_ERR_W'(ber_idx);
        if (ber_any) st_d.s0[F_ERR_LO +: F_ERR_W] = err_field;

        if (hit_any) begin
            if (st_q.irq) st_d.s0[B_SINT] = 1'b1;
            else          st_d.id = frame_ids[hit_idx*ID_W +: ID_W];
        end

        mask0_eff = st_q.ctrl;
        mask0_eff[B_UR1] = st_q.m1[B_M_UR1];
        st_d.irq = (|(st_q.s0 & ST0_SRC & ~mask0_eff)) | (|(st_q.s1 & ~st_q.m1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status0_o = st_q.s0;
    assign status1_o = st_q.s1;
    assign int_id_o  = st_q.id;
    assign irq_o     = st_q.irq;
endmodule

module dispirq_status_chk #(
    parameter int unsigned NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ev_buserr,
    input logic [NUM_CH-1:0] ev_sof,
    input logic              ev_last_done,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       mask1_q,
    input logic [NUM_CH-1:0] hit,
    input logic [31:0]       status0_o,
    input logic [31:0]       status1_o,
    input logic [31:0]       int_id_o,
    input logic              irq_o
);
    assert_word1_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status1_o & ~mask1_q)) |=> irq_o);

    assert_second_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (|hit)) |=> (status0_o[10] && $stable(int_id_o)));

    assert_buserr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_buserr) |=> status0_o[2]);

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_last_done |=> status0_o[0]);

    assert_word1_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data[0] && !ev_sof[1]) |=> !status1_o[0]);

    assert_quick_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && ctrl_q[16] && !wr_data[16]) |=> status0_o[7]);
endmodule

bind dispirq_status dispirq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_buserr    (ev_buserr),
    .ev_sof       (ev_sof),
    .ev_last_done (ev_last_done),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .ctrl_q       (st_q.ctrl),
    .mask1_q      (st_q.m1),
    .hit          (hit),
    .status0_o    (status0_o),
    .status1_o    (status1_o),
    .int_id_o     (int_id_o),
    .irq_o        (irq_o)
);

// File: tb/dispirq_status_test.sv
module dispirq_status_test;
    localparam int NCH = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NCH-1:0] sof, eof, br, ber, ur;
    logic ldone, acb, our, rdst, cmd;
    logic [31:0] fid [NCH];
    logic [NCH*32-1:0] fids;
    logic wen;
    logic [1:0] waddr;
    logic [31:0] wdata;
    logic [31:0] s0_o, s1_o, id_o;
    logic irq_o;

    always_comb for (int c = 0; c < NCH; c++) fids[c*32 +: 32] = fid[c];

    dispirq_status #(.NUM_CH(NCH), .ID_W(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(sof), .ev_eof(eof), .ev_branch(br), .ev_buserr(ber), .ev_underrun(ur),
        .ev_last_done(ldone), .ev_acbias(acb), .ev_out_underrun(our),
        .ev_read_status(rdst), .ev_command(cmd), .frame_ids(fids),
        .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
        .status0_o(s0_o), .status1_o(s1_o), .int_id_o(id_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model
    logic [31:0] m_s0, m_s1, m_ctl, m_m1, m_id;
    logic m_irq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_step();
        logic [31:0] n0, n1, mk0;
        logic [NCH-1:0] h;
        n0 = m_s0; n1 = m_s1;
        mk0 = m_ctl; mk0[5] = m_m1[24];
        if (wen) begin
            case (waddr)
                2'd0: begin n0 &= ~(wdata & 32'hFFF); if (wdata[2]) n0[30:28] = 3'd0; end
                2'd1: n1 &= ~(wdata & 32'h3E3F3F);
                2'd2: if (m_ctl[16] && !wdata[16]) n0[7] = 1'b1;
                default: ;
            endcase
        end
        n0[0] |= ldone; n0[3] |= acb; n0[6] |= our; n0[11] |= rdst; n0[12] |= cmd;
        n0[1] |= sof[0]; n0[8] |= eof[0]; n0[9] |= br[0]; n0[4] |= ur[0]; n0[5] |= ur[1];
        for (int c = 1; c < NCH; c++) begin
            n1[c-1] |= sof[c]; n1[c+7] |= eof[c]; n1[c+15] |= br[c];
            if (c >= 2) n1[c+23] |= ur[c];
        end
        if (|ber) begin n0[2] = 1'b1; n0[30:28] = 3'(lowest(ber)); end
        h[0] = (sof[0] & ~m_ctl[1]) | (eof[0] & ~m_ctl[8]) | (br[0] & ~m_ctl[9]) | ber[0];
        for (int c = 1; c < NCH; c++)
            h[c] = (sof[c] & ~m_m1[c-1]) | (eof[c] & ~m_m1[c+7]) | (br[c] & ~m_m1[c+15]) | ber[c];
        if (|h) begin
            if (m_irq) n0[10] = 1'b1;
            else m_id = fid[lowest(h)];
        end
        m_irq = (|(m_s0 & 32'h1BF3 & ~mk0)) | (|(m_s1 & ~m_m1));
        if (wen && waddr == 2'd2) m_ctl = wdata & 32'h0001_1BD3;
        if (wen && waddr == 2'd3) m_m1 = wdata & 32'h3F3F_3F3F;
        m_s0 = n0; m_s1 = n1;
    endtask

    task automatic clr_in();
        sof = '0; eof = '0; br = '0; ber = '0; ur = '0;
        ldone = 0; acb = 0; our = 0; rdst = 0; cmd = 0;
        wen = 0; waddr = '0; wdata = '0;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " status0"}, s0_o, m_s0);
        chk({tag, " status1"}, s1_o, m_s1);
        chk({tag, " id"}, id_o, m_id);
        chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
        clr_in();
    endtask

    task automatic do_reset();
        clr_in();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        m_s0 = '0; m_s1 = '0; m_ctl = '0; m_m1 = '0; m_id = '0; m_irq = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wen = 1'b1; waddr = a; wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int c = 0; c < NCH; c++) fid[c] = 32'hC0DE_0000 + 32'(c * 32'h111);
        do_reset();

        // R1 reset values
        chk("R1 status0", s0_o, 32'd0);
        chk("R1 status1", s1_o, 32'd0);
        chk("R1 id", id_o, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);

        // R2 word-0 placement
        ldone = 1; acb = 1; our = 1; rdst = 1; cmd = 1; eof[0] = 1; ur[0] = 1; ur[1] = 1;
        tick("R2");
        chk("R2 literal", s0_o, 32'h0000_1979);
        chk("R6 id from ch0 eof", id_o, fid[0]);

        // R3 word-1 placement for channel 4
        do_reset();
        sof[4] = 1; eof[4] = 1; br[4] = 1; ur[4] = 1;
        tick("R3");
        chk("R3 literal", s1_o, 32'h0808_0808);

        // R12 all channels same cycle, R6 lowest channel id
        do_reset();
        sof = '1;
        tick("R12");
        chk("R12 word1 sof bits", s1_o, 32'h0000_003F);
        chk("R12 word0 sof0", {31'd0, s0_o[1]}, 32'd1);
        chk("R6 lowest id", id_o, fid[0]);
        tick("R5 rise");
        chk("R5 irq high", {31'd0, irq_o}, 32'd1);

        // R7 secondary flag while irq high
        sof[3] = 1;
        tick("R7");
        chk("R7 sint set", {31'd0, s0_o[10]}, 32'd1);
        chk("R7 id held", id_o, fid[0]);

        // R6 lowest among ch2 eof and ch5 branch
        do_reset();
        eof[2] = 1; br[5] = 1;
        tick("R6");
        chk("R6 ch2 wins", id_o, fid[2]);

        // R5 masked event: no irq, no id
        do_reset();
        wr(2'd3, 32'h0000_0002);
        tick("R5 mask write");
        sof[2] = 1;
        tick("R5 masked");
        tick("R5 settle");
        chk("R5 masked irq low", {31'd0, irq_o}, 32'd0);
        chk("R5 masked bit set", s1_o, 32'h0000_0002);
        chk("R5 masked no id", id_o, 32'd0);

        // R4 bus errors
        do_reset();
        ber[5] = 1; ber[3] = 1;
        tick("R4");
        chk("R4 field", {29'd0, s0_o[30:28]}, 32'd3);
        chk("R4 flag", {31'd0, s0_o[2]}, 32'd1);
        chk("R4 id", id_o, fid[3]);
        tick("R4 settle");
        chk("R4 no irq", {31'd0, irq_o}, 32'd0);
        wr(2'd0, 32'h0000_0004);
        tick("R8 field clear");
        chk("R8 field cleared", s0_o, 32'd0);

        // R8 bit 12 survives
        cmd = 1; ldone = 1;
        tick("R8 setup");
        wr(2'd0, 32'hFFFF_FFFF);
        tick("R8");
        chk("R8 literal", s0_o, 32'h0000_1000);

        // R9 word-1 clear mask
        do_reset();
        br[1] = 1; ur[6] = 1; sof[6] = 1;
        tick("R9 setup");
        wr(2'd1, 32'hFFFF_FFFF);
        tick("R9");
        chk("R9 literal", s1_o, 32'h2001_0000);

        // R10 set wins over clear
        do_reset();
        ldone = 1;
        tick("R10 setup");
        wr(2'd0, 32'h0000_0001); ldone = 1;
        tick("R10");
        chk("R10 bit0 set", {31'd0, s0_o[0]}, 32'd1);

        // R11 quick-disable
        do_reset();
        wr(2'd2, 32'h0001_0000);
        tick("R11 enable");
        chk("R11 no qd yet", {31'd0, s0_o[7]}, 32'd0);
        wr(2'd2, 32'h0000_0000);
        tick("R11");
        chk("R11 qd set", {31'd0, s0_o[7]}, 32'd1);

        // random mix, model compared every cycle
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                sof[c] = ($urandom_range(0, 15) == 0);
                eof[c] = ($urandom_range(0, 15) == 0);
                br[c]  = ($urandom_range(0, 19) == 0);
                ber[c] = ($urandom_range(0, 39) == 0);
                ur[c]  = ($urandom_range(0, 29) == 0);
            end
            ldone = ($urandom_range(0, 19) == 0);
            acb   = ($urandom_range(0, 19) == 0);
            our   = ($urandom_range(0, 19) == 0);
            rdst  = ($urandom_range(0, 19) == 0);
            cmd   = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 3)), $urandom());
            if (n % 500 == 499) do_reset();
            else tick("R12 random");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule